// File: doc/BRIEF.md
# Indexed-Pointer Processor Bus Port

This block connects a 256-byte internal memory, which holds control registers and data buffers, to an external 8-bit processor bus. The bus is asynchronous: chip select, read strobe and write strobe are active low and have no timing relationship to the system clock. A single address bit chooses between the index register and the data port. The processor first writes a memory location into the index register, with the address bit low. It then moves bytes through the data port, with the address bit high. The internal pointer advances after every data-port access, so a block of bytes needs only one index write.

All three strobes pass through synchronisers. An access takes effect once, when its strobe pair closes. Write data and the address bit must stay valid until the closing edge has crossed the synchroniser. A mode input sets where the register area ends and the buffer area begins. The current split is reported as a flag that shows whether the pointer lies in buffer space.

Top module: `hbi_top`

## Requirements
- R1: After reset the pointer is 0x00 and every memory byte reads as 0x00.
- R2: A write with the address bit low (0) loads the pointer with the bus byte. A read with the address bit low returns the pointer value.
- R3: A write with the address bit high (1) stores the bus byte at the pointer location. A read with the address bit high returns the byte stored at the pointer location.
- R4: The pointer increases by one after every access with the address bit high. On reads the increase happens only after the strobe closes, so the read value stays stable for the whole strobe.
- R5: Incrementing from 0xFF gives 0x00.
- R6: An access closes at whichever comes first, chip select or the strobe going high. Each access acts exactly once, even when the second signal goes high later.
- R7: With the mode input low, `ptr_in_buf_o` is high exactly when the pointer is 0x10 or above (locations 0x00–0x0F are registers).
- R8: With the mode input high, `ptr_in_buf_o` is high exactly when the pointer is 0x40 or above (locations 0x00–0x3F are registers).
- R9: Reads with the address bit low change neither the pointer nor the memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low, asynchronous |
| rd_ni | input | 1 | Read strobe, active low, asynchronous |
| wr_ni | input | 1 | Write strobe, active low, asynchronous |
| a0_i | input | 1 | Selects index register (0) or data port (1) |
| periph_mode_i | input | 1 | Memory split: 0 gives 16 register bytes, 1 gives 64 |
| data_io | inout | 8 | Bidirectional data bus, driven while chip select and read are low |
| ptr_in_buf_o | output | 1 | High when the pointer addresses buffer space |

## Verification
The bench uses the default parameters: an 8-bit pointer, 16 host register bytes, 64 peripheral register bytes and two synchroniser stages. With these values a short run reaches the pointer wrap from 0xFF to 0x00. It also reaches both register/buffer boundaries, at 0x0F/0x10 and at 0x3F/0x40. The run includes the case where chip select closes before the write strobe. The two-stage synchroniser sets how long the bench holds data and the address bit after each strobe.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
  typedef enum logic [1:0] {
    OP_NONE,
    OP_PTR_LOAD,
    OP_DATA_WR,
    OP_DATA_RD
  } op_e;
endpackage

// File: rtl/hbi_sync.sv
module hbi_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  // reset to all ones: strobes are active low
  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stage_q[0] <= '1;
          else         stage_q[0] <= async_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stage_q[s] <= '1;
          else         stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/hbi_access_ctrl.sv
module hbi_access_ctrl
  import hbi_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_sn_i,
  input  logic              rd_sn_i,
  input  logic              wr_sn_i,
  input  logic              a0_i,
  input  logic [DATA_W-1:0] data_i,
  output op_e               op_o,
  output logic [DATA_W-1:0] wdata_o
);
  logic wr_act, rd_act;
  logic wr_act_q, rd_act_q;
  logic a0_q;
  logic [DATA_W-1:0] dat_q;

  assign wr_act = ~cs_sn_i & ~wr_sn_i;
  assign rd_act = ~cs_sn_i & ~rd_sn_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_act_q <= 1'b0;
      rd_act_q <= 1'b0;
      a0_q     <= 1'b0;
      dat_q    <= '0;
    end else begin
      wr_act_q <= wr_act;
      rd_act_q <= rd_act;
      // bus fields are held stable by the host while the strobe is seen active
      if (wr_act || rd_act) a0_q <= a0_i;
      if (wr_act)           dat_q <= data_i;
    end
  end

  // closing edge of whichever pair ends first; write takes priority
  always_comb begin
    op_o = OP_NONE;
    if (wr_act_q && !wr_act)            op_o = a0_q ? OP_DATA_WR : OP_PTR_LOAD;
    else if (rd_act_q && !rd_act && a0_q) op_o = OP_DATA_RD;
  end

  assign wdata_o = dat_q;
endmodule

// File: rtl/hbi_ptr.sv
module hbi_ptr
  import hbi_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int HOST_REGS   = 16,
  parameter int PERIPH_REGS = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  op_e               op_i,
  input  logic [ADDR_W-1:0] load_i,
  input  logic              periph_mode_i,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              in_buf_o
);
  localparam logic [ADDR_W-1:0] HostBound   = ADDR_W'(HOST_REGS);
  localparam logic [ADDR_W-1:0] PeriphBound = ADDR_W'(PERIPH_REGS);

  logic [ADDR_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else begin
      unique case (op_i)
        OP_PTR_LOAD:           ptr_q <= load_i;
        OP_DATA_WR, OP_DATA_RD: ptr_q <= ptr_q + 1'b1; // wraps naturally
        default:               ptr_q <= ptr_q;
      endcase
    end
  end

  assign ptr_o    = ptr_q;
  assign in_buf_o = ptr_q >= (periph_mode_i ? PeriphBound : HostBound);
endmodule

// File: rtl/hbi_mem.sv
module hbi_mem #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int Depth = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [Depth];

  generate
    for (genvar i = 0; i < Depth; i++) begin : g_word
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                           mem_q[i] <= '0;
        else if (we_i && addr_i == ADDR_W'(i)) mem_q[i] <= wdata_i;
      end
    end
  endgenerate

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/hbi_top.sv
module hbi_top
  import hbi_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int HOST_REGS   = 16,
  parameter int PERIPH_REGS = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_ni,
  input  logic       rd_ni,
  input  logic       wr_ni,
  input  logic       a0_i,
  input  logic       periph_mode_i,
  inout  wire  [7:0] data_io,
  output logic       ptr_in_buf_o
);
  localparam int DataW = 8;

  logic [2:0]        strb_s;
  op_e               op_w;
  logic [DataW-1:0]  wdat_w;
  logic [ADDR_W-1:0] ptr_w;
  logic [DataW-1:0]  mem_rd_w;
  logic [DataW-1:0]  bus_out;
  logic              bus_oe;

  hbi_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({cs_ni, rd_ni, wr_ni}),
    .sync_o  (strb_s)
  );

  hbi_access_ctrl #(.DATA_W(DataW)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cs_sn_i (strb_s[2]),
    .rd_sn_i (strb_s[1]),
    .wr_sn_i (strb_s[0]),
    .a0_i    (a0_i),
    .data_i  (data_io),
    .op_o    (op_w),
    .wdata_o (wdat_w)
  );

  hbi_ptr #(
    .ADDR_W(ADDR_W), .HOST_REGS(HOST_REGS), .PERIPH_REGS(PERIPH_REGS)
  ) u_ptr (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .op_i          (op_w),
    .load_i        (ADDR_W'(wdat_w)),
    .periph_mode_i (periph_mode_i),
    .ptr_o         (ptr_w),
    .in_buf_o      (ptr_in_buf_o)
  );

  hbi_mem #(.ADDR_W(ADDR_W), .DATA_W(DataW)) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (op_w == OP_DATA_WR),
    .addr_i  (ptr_w),
    .wdata_i (wdat_w),
    .rdata_o (mem_rd_w)
  );

  // read path uses raw pins so data is valid for the whole strobe
  assign bus_oe  = ~cs_ni & ~rd_ni;
  assign bus_out = a0_i ? mem_rd_w : DataW'(ptr_w);
  assign data_io = bus_oe ? bus_out : 'z;
endmodule

// File: rtl/hbi_chk.sv
module hbi_chk
  import hbi_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input op_e               op_i,
  input logic [ADDR_W-1:0] ptr_i,
  input logic [7:0]        wdat_i
);
  // R2
  ptr_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_PTR_LOAD |=> ptr_i == ADDR_W'($past(wdat_i)));

  // R4
  ptr_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_DATA_WR || op_i == OP_DATA_RD) |=> ptr_i == ADDR_W'($past(ptr_i) + 1'b1));

  // R5
  ptr_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((op_i == OP_DATA_WR || op_i == OP_DATA_RD) && ptr_i == '1) |=> ptr_i == '0);

  // R9
  ptr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_NONE |=> $stable(ptr_i));

  // R6
  single_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i != OP_NONE |=> op_i == OP_NONE);
endmodule

bind hbi_top hbi_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .op_i   (op_w),
  .ptr_i  (ptr_w),
  .wdat_i (wdat_w)
);

// File: tb/hbi_top_tb_top.sv
`timescale 1ns/1ps
module hbi_top_tb_top;
  logic clk = 0;
  logic rst_n = 0;
  logic cs_n = 1, rd_n = 1, wr_n = 1, a0 = 0, mode = 0;
  logic drv_en = 0;
  logic [7:0] drv_d = 0;
  wire  [7:0] bus;
  logic in_buf;

  int n_cmp = 0, n_bad = 0;
  bit settled = 0;
  logic [7:0] ref_mem [256];
  logic [7:0] ref_ptr = 0;

  assign bus = drv_en ? drv_d : 8'bz;

  always #10 clk = ~clk;

  hbi_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .rd_ni(rd_n), .wr_ni(wr_n),
    .a0_i(a0), .periph_mode_i(mode), .data_io(bus), .ptr_in_buf_o(in_buf)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-clock region compare (R7 R8)
  always @(negedge clk) begin
    if (rst_n && settled)
      check(mode ? "R8 region" : "R7 region", {7'd0, in_buf},
            {7'd0, ref_ptr >= (mode ? 8'h40 : 8'h10)});
  end

  task automatic bus_wr(bit addr_bit, logic [7:0] d, bit cs_first = 0);
    @(negedge clk);
    settled = 0;
    a0 = addr_bit; drv_d = d; drv_en = 1;
    cs_n = 0; wr_n = 0;
    repeat (4) @(negedge clk);
    if (cs_first) cs_n = 1; else wr_n = 1;
    repeat (5) @(negedge clk);
    cs_n = 1; wr_n = 1;
    repeat (2) @(negedge clk);
    drv_en = 0;
    if (addr_bit) begin
      ref_mem[ref_ptr] = d;
      ref_ptr = ref_ptr + 8'd1;
    end else ref_ptr = d;
    settled = 1;
  endtask

  task automatic bus_rd(bit addr_bit, string req);
    logic [7:0] exp;
    exp = addr_bit ? ref_mem[ref_ptr] : ref_ptr;
    @(negedge clk);
    settled = 0;
    a0 = addr_bit; cs_n = 0; rd_n = 0;
    repeat (3) @(negedge clk);
    check(req, bus, exp);
    repeat (3) @(negedge clk);
    check({req, " R4 stable"}, bus, exp);
    rd_n = 1; cs_n = 1;
    repeat (6) @(negedge clk);
    if (addr_bit) ref_ptr = ref_ptr + 8'd1;
    settled = 1;
  endtask

  initial begin
    #(200000 * 20);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) ref_mem[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1;
    settled = 1;
    // R1 reset state
    bus_rd(0, "R1 ptr");
    bus_rd(1, "R1 mem");
    // R2 load and read back pointer
    bus_wr(0, 8'h10);
    bus_rd(0, "R2 ptr");
    // R3 R4 block write
    for (int i = 0; i < 8; i++) bus_wr(1, 8'h80 + 8'(i * 7));
    bus_rd(0, "R4 ptr after block");
    bus_wr(0, 8'h10);
    for (int i = 0; i < 8; i++) bus_rd(1, "R3 data");
    // R9 index reads leave pointer alone
    bus_rd(0, "R9 ptr");
    bus_rd(0, "R9 ptr again");
    // R5 wrap
    bus_wr(0, 8'hFE);
    bus_wr(1, 8'hA5);
    bus_wr(1, 8'h3C);
    bus_rd(0, "R5 wrapped ptr");
    bus_wr(0, 8'hFE);
    bus_rd(1, "R5 data FE");
    bus_rd(1, "R5 data FF");
    bus_rd(0, "R5 ptr after read wrap");
    // R6 chip select closes first
    bus_wr(0, 8'h20);
    bus_wr(1, 8'h5A, 1);
    bus_rd(0, "R6 single increment");
    bus_wr(0, 8'h20);
    bus_rd(1, "R6 data");
    // R7 R8 boundaries
    bus_wr(0, 8'h0F);
    check("R7 below", {7'd0, in_buf}, 8'd0);
    bus_wr(0, 8'h10);
    check("R7 at", {7'd0, in_buf}, 8'd1);
    @(negedge clk); mode = 1;
    @(negedge clk);
    check("R8 host-boundary in periph", {7'd0, in_buf}, 8'd0);
    bus_wr(0, 8'h3F);
    check("R8 below", {7'd0, in_buf}, 8'd0);
    bus_wr(0, 8'h40);
    check("R8 at", {7'd0, in_buf}, 8'd1);
    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule